// File: doc/BRIEF.md
# Receive frame acceptance filter

This block sits behind the receive MAC of a network controller and rules on each arriving frame: keep it or drop it. It looks at two things, the frame's error flags and its 48-bit destination address. It checks them against a set of mode bits and two filter tables that a setup path has loaded earlier. The first table holds sixteen exact addresses. The second is a 512-bit hash table that serves imperfect matching.

For each destination address presented with a strobe, the block gives a single-cycle verdict pulse one clock later. A good frame, or a bad frame whose pass bit is set, is accepted when one of two conditions holds: promiscuous mode is on, or the address passes the filter that its address class selects. A multicast address and a unicast address each have their own bit that chooses between hash and exact matching. A hash-only bit forces hash matching for every frame.

Top module: `rx_accept_filter`

## Requirements
- R1: `verdict_valid` is high in exactly the cycle after each cycle in which `da_valid` is high, and is low otherwise. `verdict_accept` is never high while `verdict_valid` is low.
- R2: A synchronous active-low reset clears both outputs, marks every exact-match entry invalid and clears every hash bit. After reset, a frame seen with promiscuous mode off is therefore rejected.
- R3: A frame whose `da_runt` or `da_trunc` flag is set is rejected while `cfg_pass_bad` is 0. This holds even in promiscuous mode.
- R4: With `cfg_promisc` set, every frame that R3 does not reject is accepted, whatever its address.
- R5: With `cfg_pass_bad` set, a bad frame gets the same address decision that a good frame with the same address would get.
- R6: The group bit is `da_addr[40]`, the least significant bit of the first octet (`da_addr[47:40]`). When it is 1, `cfg_hash_mcast` is 0 and `cfg_hash_only` is 0, the frame is accepted only if an exact-match entry equals it.
- R7: A group address with `cfg_hash_mcast` set is accepted only if its hash bit is set.
- R8: An individual address (group bit 0) uses the hash table when `cfg_hash_ucast` is 1 and the exact-match table when it is 0.
- R9: With `cfg_hash_only` set, every address is judged by its hash bit alone. This overrides `cfg_hash_mcast` and `cfg_hash_ucast`.
- R10: The hash bit of an address is table bit `crc[8:0]`. Here `crc` is the CRC-32 register (reflected polynomial 0xEDB88320, preset to all ones, no final inversion) after the six octets have been shifted in. The octets go in order from `da_addr[47:40]` down to `da_addr[7:0]`, each octet least significant bit first. A write with `tw_hash`=1 sets bit `tw_index` to `tw_set`.
- R11: A write with `tw_hash`=0 loads `tw_addr` into exact-match entry `tw_index[3:0]` and sets that entry's valid flag to `tw_set`. An address matches if any valid entry equals it. An invalid entry never matches.
- R12: The broadcast address (all ones) is a group address and follows R6, R7 and R9.
- R13: A table write affects verdicts only for strobes in later cycles. A strobe in the same cycle as a write sees the old table contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| da_valid | input | 1 | Destination address strobe, one cycle per frame |
| da_addr | input | 48 | Destination address, first octet in [47:40] |
| da_runt | input | 1 | Frame is shorter than the minimum length |
| da_trunc | input | 1 | Frame was cut short by a receive overflow |
| cfg_promisc | input | 1 | Accept every frame not dropped for errors |
| cfg_pass_bad | input | 1 | Let bad frames go on to address filtering |
| cfg_hash_only | input | 1 | Judge every address by the hash table |
| cfg_hash_mcast | input | 1 | Group addresses use the hash table |
| cfg_hash_ucast | input | 1 | Individual addresses use the hash table |
| tw_en | input | 1 | Table write strobe |
| tw_hash | input | 1 | Write target: 1 hash table, 0 exact-match table |
| tw_index | input | 9 | Hash bit number, or exact-match entry in [3:0] |
| tw_addr | input | 48 | Address loaded into an exact-match entry |
| tw_set | input | 1 | Hash bit value or exact-match entry valid flag |
| verdict_valid | output | 1 | Verdict pulse |
| verdict_accept | output | 1 | Frame is kept, qualified by verdict_valid |

## Verification
Every verdict is due exactly one clock after its address strobe. A table write counts from the next clock onward, so a strobe in the same cycle as a write must be judged on the old contents. The bench keeps a behavioural model of both tables. On each rising edge the model works out the expected verdict from the inputs in force at that edge and from the tables as they stood before any write in that edge. The model registers that verdict, and the bench compares it with the outputs on the following falling edge, in every cycle including idle and reset cycles. Hash bits are placed with a CRC routine in the bench that follows the bit order given in R10.

// File: rtl/rxf_pkg.sv
// Shared definitions for the receive acceptance filter.
// Assumes: nothing beyond IEEE 1800-2017.
package rxf_pkg;

    // Reflected CRC-32 polynomial used for the hash index.
    localparam logic [31:0] CRC32_POLY_REFL = 32'hEDB8_8320;

    // Which table a write port access targets.
    typedef enum logic {
        TBL_EXACT = 1'b0,
        TBL_HASH  = 1'b1
    } tbl_kind_e;

    // Mode bits gathered in one place.
    typedef struct packed {
        logic promisc;
        logic pass_bad;
        logic hash_only;
        logic hash_mcast;
        logic hash_ucast;
    } filt_mode_t;

endpackage

// File: rtl/rxf_hash_index.sv
// Computes the hash table index of a destination address: the low IDX_W
// bits of a reflected CRC-32 (preset all ones, no final inversion) over the
// address octets, first octet in the top byte, each octet LSB first.
// Assumes: ADDR_W is a multiple of 8; purely combinational.
module rxf_hash_index
    import rxf_pkg::*;
#(
    parameter int ADDR_W = 48,
    parameter int IDX_W  = 9
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx
);

    localparam int NBYTES = ADDR_W / 8;

    logic [31:0] crc;
    logic        fb;

    // Unrolled serial CRC over all address bits in wire order.
    always_comb begin
        crc = '1;
        fb  = 1'b0;
        for (int b = 0; b < NBYTES; b++) begin
            for (int i = 0; i < 8; i++) begin
                fb  = crc[0] ^ addr[ADDR_W - 8 - 8*b + i];
                crc = {1'b0, crc[31:1]} ^ (fb ? CRC32_POLY_REFL : 32'h0);
            end
        end
        idx = crc[IDX_W-1:0];
    end

endmodule

// File: rtl/rxf_hash_table.sv
// Bit-addressable hash table of 2**IDX_W flags with one write port and one
// combinational read port. A write becomes visible on the next cycle.
// Assumes: synchronous active-low reset clears every bit.
module rxf_hash_table #(
    parameter int IDX_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_val,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_bit
);

    localparam int DEPTH = 1 << IDX_W;

    logic [DEPTH-1:0] bits_q;

    // Storage update: reset clears, a write sets one bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bits_q <= '0;
        end else if (wr_en) begin
            bits_q[wr_idx] <= wr_val;
        end
    end

    // Read the addressed flag.
    assign rd_bit = bits_q[rd_idx];

    // R10: the written bit holds the written value one cycle later.
    p_hash_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (bits_q[$past(wr_idx)] == $past(wr_val)));

endmodule

// File: rtl/rxf_perfect_table.sv
// Exact-match address table of ENTRIES entries, each with a valid flag.
// All entries are compared in parallel; hit is the OR of the valid matches.
// Assumes: entry contents need no reset, only the valid flags do.
module rxf_perfect_table #(
    parameter int ADDR_W  = 48,
    parameter int ENTRIES = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [$clog2(ENTRIES)-1:0] wr_idx,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic                       wr_valid,
    input  logic [ADDR_W-1:0]          lookup,
    output logic                       hit
);

    logic [ADDR_W-1:0]  ent_q [ENTRIES];
    logic [ENTRIES-1:0] ent_v_q;
    logic [ENTRIES-1:0] match;

    // Valid flags: reset invalidates all, a write sets the chosen flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_v_q <= '0;
        end else if (wr_en) begin
            ent_v_q[wr_idx] <= wr_valid;
        end
    end

    // Entry contents: loaded on any write to the entry.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            ent_q[wr_idx] <= wr_addr;
        end
    end

    // One comparator per entry.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = ent_v_q[g] && (ent_q[g] == lookup);
    end

    // Any valid match is a hit.
    assign hit = |match;

    // R11: a write leaves the entry with the written flag and address.
    p_exact_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (ent_v_q[$past(wr_idx)] == $past(wr_valid)) &&
                  (ent_q[$past(wr_idx)] == $past(wr_addr)));

    // R11: with no valid entry there is never a hit.
    p_no_valid_no_hit_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ent_v_q == '0) |-> !hit);

endmodule

// File: rtl/rx_accept_filter.sv
// Receive frame acceptance filter. Combines the error flags, the mode bits
// and the two filter tables into a registered keep/drop verdict that
// appears one cycle after each address strobe.
// Assumes: tw_index is wide enough to address every exact-match entry;
// synchronous active-low reset.
module rx_accept_filter
    import rxf_pkg::*;
#(
    parameter int ADDR_W       = 48,
    parameter int PERF_ENTRIES = 16,
    parameter int HASH_IDX_W   = 9
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  da_valid,
    input  logic [ADDR_W-1:0]     da_addr,
    input  logic                  da_runt,
    input  logic                  da_trunc,
    input  logic                  cfg_promisc,
    input  logic                  cfg_pass_bad,
    input  logic                  cfg_hash_only,
    input  logic                  cfg_hash_mcast,
    input  logic                  cfg_hash_ucast,
    input  logic                  tw_en,
    input  logic                  tw_hash,
    input  logic [HASH_IDX_W-1:0] tw_index,
    input  logic [ADDR_W-1:0]     tw_addr,
    input  logic                  tw_set,
    output logic                  verdict_valid,
    output logic                  verdict_accept
);

    localparam int PERF_IW   = $clog2(PERF_ENTRIES);
    localparam int GROUP_BIT = ADDR_W - 8;

    filt_mode_t          mode;
    tbl_kind_e           tw_kind;
    logic                wr_exact;
    logic                wr_hash;
    logic [HASH_IDX_W-1:0] hash_idx;
    logic                hash_hit;
    logic                exact_hit;
    logic                frame_bad;
    logic                drop_bad;
    logic                is_group;
    logic                use_hash;
    logic                addr_ok;
    logic                accept_d;

    // Gather mode bits and decode the write target.
    always_comb begin
        mode.promisc    = cfg_promisc;
        mode.pass_bad   = cfg_pass_bad;
        mode.hash_only  = cfg_hash_only;
        mode.hash_mcast = cfg_hash_mcast;
        mode.hash_ucast = cfg_hash_ucast;
        tw_kind         = tbl_kind_e'(tw_hash);
        wr_exact        = tw_en && (tw_kind == TBL_EXACT);
        wr_hash         = tw_en && (tw_kind == TBL_HASH);
    end

    rxf_hash_index #(
        .ADDR_W (ADDR_W),
        .IDX_W  (HASH_IDX_W)
    ) u_hidx (
        .addr (da_addr),
        .idx  (hash_idx)
    );

    rxf_hash_table #(
        .IDX_W (HASH_IDX_W)
    ) u_hash (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_hash),
        .wr_idx (tw_index),
        .wr_val (tw_set),
        .rd_idx (hash_idx),
        .rd_bit (hash_hit)
    );

    rxf_perfect_table #(
        .ADDR_W  (ADDR_W),
        .ENTRIES (PERF_ENTRIES)
    ) u_exact (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_exact),
        .wr_idx   (tw_index[PERF_IW-1:0]),
        .wr_addr  (tw_addr),
        .wr_valid (tw_set),
        .lookup   (da_addr),
        .hit      (exact_hit)
    );

    // Decision: error gate first, then promiscuous bypass, then address class.
    always_comb begin
        frame_bad = da_runt || da_trunc;
        drop_bad  = frame_bad && !mode.pass_bad;
        is_group  = da_addr[GROUP_BIT];
        use_hash  = mode.hash_only || (is_group ? mode.hash_mcast : mode.hash_ucast);
        addr_ok   = use_hash ? hash_hit : exact_hit;
        accept_d  = !drop_bad && (mode.promisc || addr_ok);
    end

    // Verdict register: one pulse per strobe, accept qualified by the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            verdict_valid  <= 1'b0;
            verdict_accept <= 1'b0;
        end else begin
            verdict_valid  <= da_valid;
            verdict_accept <= da_valid && accept_d;
        end
    end

    // R1: a strobe yields a verdict on the next cycle.
    p_verdict_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
        da_valid |=> verdict_valid);

    // R1: no strobe, no verdict on the next cycle.
    p_verdict_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !da_valid |=> !verdict_valid);

    // R1: accept is only ever raised alongside valid.
    p_accept_qualified_r1: assert property (@(posedge clk) disable iff (!rst_n)
        verdict_accept |-> verdict_valid);

    // R3: bad frames are dropped unless passing of bad frames is enabled.
    p_bad_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (da_valid && (da_runt || da_trunc) && !cfg_pass_bad) |=> !verdict_accept);

    // R4: promiscuous mode keeps every frame that survives the error gate.
    p_promisc_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (da_valid && cfg_promisc && (cfg_pass_bad || !(da_runt || da_trunc)))
        |=> verdict_accept);

    // R9: in hash-only mode a clear hash bit drops a non-promiscuous frame.
    p_hash_only_miss_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (da_valid && cfg_hash_only && !cfg_promisc && !hash_hit) |=> !verdict_accept);

    // R6: an exact-filtered group address with no table hit is dropped.
    p_group_exact_miss_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (da_valid && !cfg_promisc && !cfg_hash_only && !cfg_hash_mcast &&
         da_addr[GROUP_BIT] && !exact_hit) |=> !verdict_accept);

endmodule

// File: tb/rx_accept_filter_tb_top.sv
`timescale 1ns/1ps
module rx_accept_filter_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        da_valid = 1'b0;
    logic [47:0] da_addr = '0;
    logic        da_runt = 1'b0, da_trunc = 1'b0;
    logic        cfg_promisc = 1'b0, cfg_pass_bad = 1'b0, cfg_hash_only = 1'b0;
    logic        cfg_hash_mcast = 1'b0, cfg_hash_ucast = 1'b0;
    logic        tw_en = 1'b0, tw_hash = 1'b0, tw_set = 1'b0;
    logic [8:0]  tw_index = '0;
    logic [47:0] tw_addr = '0;
    logic        verdict_valid, verdict_accept;

    int    checks = 0;
    int    failures = 0;
    bit    done = 1'b0;
    string scen = "R2 reset";

    always #2.5 clk = ~clk;

    rx_accept_filter dut_i (
        .clk(clk), .rst_n(rst_n), .da_valid(da_valid), .da_addr(da_addr),
        .da_runt(da_runt), .da_trunc(da_trunc), .cfg_promisc(cfg_promisc),
        .cfg_pass_bad(cfg_pass_bad), .cfg_hash_only(cfg_hash_only),
        .cfg_hash_mcast(cfg_hash_mcast), .cfg_hash_ucast(cfg_hash_ucast),
        .tw_en(tw_en), .tw_hash(tw_hash), .tw_index(tw_index), .tw_addr(tw_addr),
        .tw_set(tw_set), .verdict_valid(verdict_valid), .verdict_accept(verdict_accept)
    );

    // Hash bit number per R10, written as a serial bit stream.
    function automatic int tb_hidx(input logic [47:0] a);
        bit [31:0] c = 32'hFFFF_FFFF;
        for (int k = 0; k < 48; k++) begin
            int pos = 40 - 8 * (k / 8) + (k % 8);
            if (c[0] ^ a[pos]) c = (c >> 1) ^ 32'hEDB8_8320;
            else               c = c >> 1;
        end
        return int'(c[8:0]);
    endfunction

    // Behavioural reference model.
    bit [47:0] m_addr [16];
    bit        m_v [16];
    bit        m_hash [512];
    bit        exp_v = 1'b0, exp_a = 1'b0;
    string     exp_tag = "R2";

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_v[i]) m_v[i] = 1'b0;
            foreach (m_hash[i]) m_hash[i] = 1'b0;
            exp_v   <= 1'b0;
            exp_a   <= 1'b0;
            exp_tag <= "R2";
        end else begin
            bit bad, grp, hashy, inexact, ok;
            string t;
            bad = da_runt | da_trunc;
            grp = da_addr[40];
            inexact = 1'b0;
            for (int i = 0; i < 16; i++)
                if (m_v[i] && m_addr[i] == da_addr) inexact = 1'b1;
            hashy = cfg_hash_only || (grp ? cfg_hash_mcast : cfg_hash_ucast);
            ok = hashy ? m_hash[tb_hidx(da_addr)] : inexact;
            if (bad && !cfg_pass_bad)   begin t = "R3"; ok = 1'b0; end
            else if (cfg_promisc)       begin t = "R4"; ok = 1'b1; end
            else if (bad)                     t = "R5";
            else if (cfg_hash_only)           t = "R9";
            else if (da_addr == '1)           t = "R12";
            else if (grp)                     t = cfg_hash_mcast ? "R7" : "R6";
            else                              t = "R8";
            exp_v   <= da_valid;
            exp_a   <= da_valid && ok;
            exp_tag <= da_valid ? t : "R1";
            if (tw_en) begin
                if (tw_hash) m_hash[tw_index] = tw_set;
                else begin
                    m_addr[tw_index[3:0]] = tw_addr;
                    m_v[tw_index[3:0]]    = tw_set;
                end
            end
        end
    end

    // Compare outputs with the model away from the active edge.
    always @(negedge clk) begin
        if (!done) begin
            checks++;
            if (verdict_valid !== exp_v || verdict_accept !== exp_a) begin
                failures++;
                $display("FAIL %s (%s): valid/accept actual=%0b/%0b expected=%0b/%0b",
                         exp_tag, scen, verdict_valid, verdict_accept, exp_v, exp_a);
            end
        end
    end

    task automatic frame(input logic [47:0] a, input bit runt = 0, input bit trunc = 0);
        da_valid = 1'b1; da_addr = a; da_runt = runt; da_trunc = trunc;
        @(negedge clk);
        da_valid = 1'b0; da_runt = 1'b0; da_trunc = 1'b0;
        @(negedge clk);
    endtask

    task automatic wr_exact(input int idx, input logic [47:0] a, input bit v);
        tw_en = 1'b1; tw_hash = 1'b0; tw_index = 9'(idx); tw_addr = a; tw_set = v;
        @(negedge clk);
        tw_en = 1'b0;
    endtask

    task automatic wr_hashbit(input logic [47:0] a, input bit v);
        tw_en = 1'b1; tw_hash = 1'b1; tw_index = 9'(tb_hidx(a)); tw_set = v;
        @(negedge clk);
        tw_en = 1'b0;
    endtask

    localparam logic [47:0] UC_A  = 48'h00_11_22_33_44_55;
    localparam logic [47:0] UC_B  = 48'h02_AB_CD_EF_01_23;
    localparam logic [47:0] MC_A  = 48'h01_00_5E_00_00_01;
    localparam logic [47:0] MC_B  = 48'h33_33_00_00_00_FB;
    localparam logic [47:0] BCAST = 48'hFF_FF_FF_FF_FF_FF;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        scen = "R2 empty tables";
        frame(UC_A); frame(MC_A); frame(BCAST);

        scen = "R11 exact entries";
        wr_exact(3, UC_A, 1'b1);
        frame(UC_A); frame(UC_B);
        wr_exact(15, UC_B, 1'b1);
        frame(UC_B);
        wr_exact(3, UC_A, 1'b0);
        frame(UC_A);

        scen = "R6 group exact";
        wr_exact(0, MC_A, 1'b1);
        frame(MC_A); frame(MC_B);

        scen = "R10 R7 group hash";
        cfg_hash_mcast = 1'b1;
        frame(MC_A);
        wr_hashbit(MC_B, 1'b1);
        frame(MC_B); frame(MC_A);

        scen = "R12 broadcast";
        frame(BCAST);
        wr_hashbit(BCAST, 1'b1);
        frame(BCAST);
        cfg_hash_mcast = 1'b0;
        frame(BCAST);

        scen = "R8 individual";
        frame(UC_B);
        cfg_hash_ucast = 1'b1;
        frame(UC_B);
        wr_hashbit(UC_B, 1'b1);
        frame(UC_B);
        cfg_hash_ucast = 1'b0;

        scen = "R9 hash only";
        cfg_hash_only = 1'b1;
        frame(MC_A); frame(MC_B); frame(UC_B); frame(BCAST);
        wr_hashbit(UC_B, 1'b0);
        frame(UC_B);
        cfg_hash_only = 1'b0;

        scen = "R3 R4 R5 bad frames";
        frame(UC_B, 1, 0); frame(UC_B, 0, 1);
        cfg_promisc = 1'b1;
        frame(UC_A); frame(UC_A, 1, 0);
        cfg_pass_bad = 1'b1;
        frame(UC_A, 0, 1);
        cfg_promisc = 1'b0;
        frame(UC_B, 1, 0); frame(UC_A, 0, 1); frame(MC_A, 1, 1);
        cfg_pass_bad = 1'b0;

        scen = "R13 write timing";
        tw_en = 1'b1; tw_hash = 1'b0; tw_index = 9'd7; tw_addr = UC_A; tw_set = 1'b1;
        da_valid = 1'b1; da_addr = UC_A;
        @(negedge clk);
        tw_en = 1'b0;
        @(negedge clk);
        da_valid = 1'b0;
        @(negedge clk);

        scen = "R1 back to back";
        da_valid = 1'b1; da_addr = UC_A;
        @(negedge clk);
        da_addr = UC_B;
        @(negedge clk);
        da_addr = MC_A;
        @(negedge clk);
        da_valid = 1'b0;
        repeat (2) @(negedge clk);

        scen = "R2 reset again";
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        frame(UC_A); frame(MC_A);
        repeat (2) @(negedge clk);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule